// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface. It owns the command pins from reset until the memory is usable, then keeps the memory's contents alive. Once reset is released it drives a quiet bus: no-operation commands, clock enable high and the data mask high. It holds that bus for a programmable number of cycles. It then closes every bank with a precharge-all, lets the row-precharge time pass, and runs a programmable number of auto-refresh cycles (eight or more). Each refresh is followed by a row-cycle gap. Last, it loads the mode register and raises `init_done` once the mode-set recovery time has passed.

After that point the sequencer switches to a periodic scheduler. A free-running interval counter raises `ref_req` once per refresh interval. The interval is a parameter, normally 64 ms divided by 4096, expressed in clocks. The request stays pending until the memory arbiter answers with `ref_gnt`, and the sequencer then issues one auto-refresh followed by a row-cycle gap. Every delay is a parameter counted in clock cycles. The mode word is built from parameters: burst length code, burst type, CAS latency and write mode.

The state machine has ten states:
- `ST_PWR_WAIT` → `ST_PRECH` when the power-up count expires.
- `ST_PRECH` → `ST_TRP_WAIT`.
- `ST_TRP_WAIT` → `ST_AREF` when the precharge count expires.
- `ST_AREF` → `ST_TRC_WAIT`.
- `ST_TRC_WAIT` → `ST_AREF` while start-up refreshes remain, otherwise → `ST_MRS`.
- `ST_MRS` → `ST_TRSC_WAIT`.
- `ST_TRSC_WAIT` → `ST_READY`.
- `ST_READY` → `ST_RUN_REF` on a granted pending request.
- `ST_RUN_REF` → `ST_RUN_TRC`.
- `ST_RUN_TRC` → `ST_READY` when the row-cycle count expires.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is asserted the command is NOP, `cke` is 1, `dqm` is 1, and both `init_done` and `ref_req` are 0. The command is {cs_n,ras_n,cas_n,we_n}: NOP=0111, PRE=0010, REF=0001, MRS=0000.
- R2: After reset is released, exactly POWERUP_CYC cycles of NOP are driven. The next cycle carries a PRE with `addr[10]`=1 (all banks) and `ba`=0.
- R3: The first auto-refresh (REF) follows the precharge-all exactly T_RP_CYC cycles later.
- R4: Exactly INIT_REF_CNT start-up REF commands are issued, consecutive ones T_RC_CYC cycles apart. The MRS comes T_RC_CYC cycles after the last of them.
- R5: The MRS carries `ba`=0 and the mode word on `addr`: bits 2:0 burst length code, bit 3 burst type, bits 6:4 CAS latency (2 or 3), bits 8:7 zero, bit 9 write mode (1 = single write), bits above 9 zero.
- R6: `init_done` rises exactly T_RSC_CYC cycles after the MRS cycle and then stays high until reset. `dqm` drops to 0 from that same cycle.
- R7: `ref_req` rises REFI_CYC cycles after `init_done` rises, and rises again every REFI_CYC cycles after that.
- R8: A pending `ref_req` stays high until it is served. No run-time REF is issued without `ref_gnt` sampled high together with `ref_req`; a grant while no request is pending has no effect.
- R9: A grant sampled with a pending request in the ready state yields a REF in the next cycle. `ref_req` falls one cycle after that REF. The next command comes no sooner than T_RC_CYC cycles after the REF.
- R10: Every non-NOP command is followed by at least one NOP cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands change at its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant for a pending refresh |
| ref_req | output | 1 | Pending periodic refresh request |
| init_done | output | 1 | Start-up sequence complete, memory usable |
| cke | output | 1 | SDRAM clock enable (held high) |
| dqm | output | 1 | Data mask, high until start-up completes |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |

## Verification
Some behaviours are checked on every cycle by the assertions:
- `init_done` never falls once set.
- Each command is followed by a NOP.
- A precharge-all and a mode write appear only before ready.
- A run-time refresh always follows a sampled grant on a pending request.
- A pending request is never dropped unserved.
- The wait timer steps down by one.

The exact cycle positions can only be shown by the bench's scenarios. These cover the length of the power-up wait, the precharge, row-cycle and mode-set gaps, the number of start-up refreshes, the mode word bit layout, and the request period. The scenarios also show that a stray grant with no request is ignored and that a held grant serves each new request exactly once.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command code packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_PRECH,
        ST_TRP_WAIT,
        ST_AREF,
        ST_TRC_WAIT,
        ST_MRS,
        ST_TRSC_WAIT,
        ST_READY,
        ST_RUN_REF,
        ST_RUN_TRC
    } seq_state_e;

    // Address bit that selects all banks on a precharge
    localparam int unsigned ALL_BANK_BIT = 10;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // Load value giving a command-to-command spacing of t cycles
    function automatic int unsigned gap_load(input int unsigned t);
        return (t < 2) ? 0 : t - 2;
    endfunction

    // Mode word: [2:0] burst length code, [3] burst type,
    // [6:4] CAS latency, [8:7] zero, [9] write mode, [11:10] zero
    function automatic logic [11:0] build_mode_word(input logic [2:0] bl_code,
                                                    input logic       burst_type,
                                                    input logic [2:0] cas_lat,
                                                    input logic       single_write);
        logic [11:0] w;
        w        = '0;
        w[2:0]   = bl_code;
        w[3]     = burst_type;
        w[6:4]   = cas_lat;
        w[9]     = single_write;
        return w;
    endfunction

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
    parameter int unsigned REFI_CYC = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic served,
    output logic ref_req
);

    localparam int unsigned     CNT_W = $clog2(REFI_CYC + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(REFI_CYC - 1);

    logic [CNT_W-1:0] ivl_q;
    logic             tick;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ivl_q <= '0;
        end else if (ivl_q == LAST) begin
            ivl_q <= '0;
        end else begin
            ivl_q <= ivl_q + 1'b1;
        end
    end

    assign tick = run && (ivl_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (tick) begin
            pend_q <= 1'b1;
        end else if (served) begin
            pend_q <= 1'b0;
        end
    end

    assign ref_req = pend_q;

    AST_REQ_HELD_UNTIL_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !served) |=> ref_req); // R8

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned BA_W         = 2,
    parameter int unsigned POWERUP_CYC  = 62500,
    parameter int unsigned T_RP_CYC     = 3,
    parameter int unsigned T_RC_CYC     = 9,
    parameter int unsigned T_RSC_CYC    = 2,
    parameter int unsigned INIT_REF_CNT = 8,
    parameter int unsigned REFI_CYC     = 1953,
    parameter logic [2:0]  BL_CODE      = 3'b011,
    parameter logic        BURST_TYPE   = 1'b0,
    parameter logic [2:0]  CAS_LAT      = 3'b011,
    parameter logic        SINGLE_WRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              init_done,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned MAX_DLY = max4(POWERUP_CYC, T_RP_CYC, T_RC_CYC, T_RSC_CYC);
    localparam int unsigned TMR_W   = $clog2(MAX_DLY + 1);
    localparam int unsigned PWR_RST = (POWERUP_CYC < 1) ? 0 : POWERUP_CYC - 1;
    localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(gap_load(T_RP_CYC));
    localparam logic [TMR_W-1:0] LD_RC  = TMR_W'(gap_load(T_RC_CYC));
    localparam logic [TMR_W-1:0] LD_RSC = TMR_W'(gap_load(T_RSC_CYC));
    localparam int unsigned REFN_W  = $clog2(INIT_REF_CNT + 1);
    localparam logic [REFN_W-1:0] REF_LAST = REFN_W'(INIT_REF_CNT);
    localparam logic [11:0] MODE_WORD =
        build_mode_word(BL_CODE, BURST_TYPE, CAS_LAT, SINGLE_WRITE);

    seq_state_e        state_q, state_d;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic [REFN_W-1:0] ref_num_q;
    logic              run_mode;
    logic              ref_served;
    sdr_cmd_e          cmd;

    // Shared down-counter for every fixed gap in the sequence
    sdram_wait_timer #(
        .CNT_W   (TMR_W),
        .RST_VAL (PWR_RST)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // Periodic refresh interval and pending flag
    sdram_refresh_sched #(
        .REFI_CYC (REFI_CYC)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_mode),
        .served  (ref_served),
        .ref_req (ref_req)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWR_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Start-up refresh counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_num_q <= '0;
        end else if (state_q == ST_AREF) begin
            ref_num_q <= ref_num_q + 1'b1;
        end
    end

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PWR_WAIT: begin
                if (tmr_done) state_d = ST_PRECH;
            end
            ST_PRECH: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
                state_d  = ST_TRP_WAIT;
            end
            ST_TRP_WAIT: begin
                if (tmr_done) state_d = ST_AREF;
            end
            ST_AREF: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RC;
                state_d  = ST_TRC_WAIT;
            end
            ST_TRC_WAIT: begin
                if (tmr_done) begin
                    state_d = (ref_num_q >= REF_LAST) ? ST_MRS : ST_AREF;
                end
            end
            ST_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RSC;
                state_d  = ST_TRSC_WAIT;
            end
            ST_TRSC_WAIT: begin
                if (tmr_done) state_d = ST_READY;
            end
            ST_READY: begin
                if (ref_req && ref_gnt) state_d = ST_RUN_REF;
            end
            ST_RUN_REF: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RC;
                state_d  = ST_RUN_TRC;
            end
            ST_RUN_TRC: begin
                if (tmr_done) state_d = ST_READY;
            end
            default: state_d = ST_PWR_WAIT;
        endcase
    end

    // Command and pin outputs
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (state_q)
            ST_PRECH: begin
                cmd                = CMD_PRE;
                addr[ALL_BANK_BIT] = 1'b1;
            end
            ST_AREF, ST_RUN_REF: begin
                cmd = CMD_REF;
            end
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = ADDR_W'(MODE_WORD);
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign run_mode   = (state_q == ST_READY) || (state_q == ST_RUN_REF) ||
                        (state_q == ST_RUN_TRC);
    assign ref_served = (state_q == ST_RUN_REF);
    assign init_done  = run_mode;
    assign dqm        = !run_mode;
    assign cke        = 1'b1;

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R6

    AST_NOP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} != 4'b0111) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R10

    AST_RUN_REF_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0001) |-> $past(ref_gnt && ref_req)); // R8

    AST_PRE_ALL_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr[ALL_BANK_BIT] && !init_done)); // R2

    AST_MRS_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0000) |-> !init_done); // R5

endmodule

// File: tb/sdram_init_refresh_tb.sv
module sdram_init_refresh_tb_top;

    localparam int unsigned PWR   = 20;
    localparam int unsigned TRP   = 3;
    localparam int unsigned TRC   = 5;
    localparam int unsigned TRSC  = 2;
    localparam int unsigned NREF  = 8;
    localparam int unsigned REFI  = 40;
    localparam logic [3:0]  NOP_C = 4'b0111;
    localparam logic [3:0]  PRE_C = 4'b0010;
    localparam logic [3:0]  REF_C = 4'b0001;
    localparam logic [3:0]  MRS_C = 4'b0000;
    // Mode word from R5 layout: write mode 1, CL 2, burst type 1, BL code 010
    localparam logic [11:0] MODE_EXP = {2'b00, 1'b1, 2'b00, 3'b010, 1'b1, 3'b010};
    localparam int MRS_AT   = PWR + TRP + NREF * TRC;
    localparam int READY_AT = MRS_AT + TRSC;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_gnt;
    logic        ref_req, init_done, cke, dqm, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;

    always #4 clk = ~clk;

    sdram_init_refresh #(
        .ADDR_W(12), .BA_W(2), .POWERUP_CYC(PWR), .T_RP_CYC(TRP), .T_RC_CYC(TRC),
        .T_RSC_CYC(TRSC), .INIT_REF_CNT(NREF), .REFI_CYC(REFI),
        .BL_CODE(3'b010), .BURST_TYPE(1'b1), .CAS_LAT(3'b010), .SINGLE_WRITE(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .init_done(init_done), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic push(input int c, input logic [3:0] cm, input logic [11:0] a, input string tag);
        exp_t e;
        e.cyc = c; e.cmd = cm; e.addr = a; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) @(negedge clk);
    endtask

    // Scoreboard monitor: every non-NOP command must match the next expected item
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] cv;
            cv = {cs_n, ras_n, cas_n, we_n};
            if (cv != NOP_C) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected command", cv, NOP_C);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
                    check(cv == e.cmd, {e.tag, " command"}, cv, e.cmd);
                    check(addr == e.addr && ba == 2'b00, {e.tag, " address"}, addr, e.addr);
                end
            end
        end
    end

    initial begin
        rst_n   = 1'b0;
        ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({cs_n, ras_n, cas_n, we_n} == NOP_C, "R1 command", {cs_n, ras_n, cas_n, we_n}, NOP_C);
        check(cke == 1'b1 && dqm == 1'b1, "R1 cke/dqm", {cke, dqm}, 2'b11);
        check(init_done == 1'b0 && ref_req == 1'b0, "R1 ready/req", {init_done, ref_req}, 2'b00);

        push(PWR, PRE_C, 12'h400, "R2 precharge-all");
        for (int i = 0; i < NREF; i++) begin
            push(PWR + TRP + i * TRC, REF_C, 12'h000, (i == 0) ? "R3 first refresh" : "R4 refresh");
        end
        push(MRS_AT, MRS_C, MODE_EXP, "R5 mode write");
        rst_n = 1'b1;

        wait_cyc(PWR - 1);
        check(dqm == 1'b1 && cke == 1'b1, "R2 quiet bus", {cke, dqm}, 2'b11);
        wait_cyc(READY_AT - 1);
        check(init_done == 1'b0, "R6 ready early", init_done, 0);
        wait_cyc(READY_AT);
        check(init_done == 1'b1, "R6 ready", init_done, 1);
        check(dqm == 1'b0, "R6 dqm released", dqm, 0);
        check(ref_req == 1'b0, "R7 no request at ready", ref_req, 0);

        // Stray grant with no request pending: monitor flags any command
        wait_cyc(READY_AT + 5);
        ref_gnt = 1'b1;
        wait_cyc(READY_AT + 10);
        ref_gnt = 1'b0;

        wait_cyc(READY_AT + REFI - 1);
        check(ref_req == 1'b0, "R7 request early", ref_req, 0);
        wait_cyc(READY_AT + REFI);
        check(ref_req == 1'b1, "R7 first request", ref_req, 1);
        for (int k = 1; k <= 6; k++) begin
            wait_cyc(READY_AT + REFI + k);
            check(ref_req == 1'b1, "R8 request held", ref_req, 1);
        end

        // Late grant
        ref_gnt = 1'b1;
        push(READY_AT + REFI + 7, REF_C, 12'h000, "R9 granted refresh");
        wait_cyc(READY_AT + REFI + 7);
        ref_gnt = 1'b0;
        wait_cyc(READY_AT + REFI + 8);
        check(ref_req == 1'b0, "R9 request cleared", ref_req, 0);

        // Grant held high across two intervals
        wait_cyc(READY_AT + 2 * REFI);
        check(ref_req == 1'b1, "R7 second request", ref_req, 1);
        ref_gnt = 1'b1;
        push(READY_AT + 2 * REFI + 1, REF_C, 12'h000, "R9 prompt refresh");
        push(READY_AT + 3 * REFI + 1, REF_C, 12'h000, "R9 held-grant refresh");
        wait_cyc(READY_AT + 2 * REFI + 2);
        check(ref_req == 1'b0, "R9 request cleared", ref_req, 0);
        wait_cyc(READY_AT + 3 * REFI);
        check(ref_req == 1'b1, "R7 third request", ref_req, 1);
        wait_cyc(READY_AT + 3 * REFI + 2);
        ref_gnt = 1'b0;
        check(init_done == 1'b1, "R6 ready sticky", init_done, 1);

        wait_cyc(READY_AT + 4 * REFI + 5);
        check(ref_req == 1'b1, "R8 ungranted request held", ref_req, 1);
        check(exp_q.size() == 0, "R4 all expected commands seen", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule